// File: doc/BRIEF.md
# Paged Packet Buffer Byte Window

This block gives a host byte-wide access into a packet buffer split into fixed-size pages (four pages of 2048 bytes by default). The host does not address the buffer directly. It loads a 16-bit pointer and a page-number register, then reads or writes bytes through a four-byte data window. The pointer picks which page is accessed. Its top bit chooses between the page at the head of the receive queue, supplied on an input, and the page held in the page-number register. Its low eleven bits give the byte position inside the page.

Bit 14 of the pointer picks one of two addressing styles. With the bit set, every window access moves the pointer on by one byte, so a driver can stream a whole page through any window address. With the bit clear, the pointer stays where it is and the low two bits of the window address are added to the position. The four window addresses then reach four neighbouring bytes. The host makes one byte access per cycle. A wider host transfer is issued as byte accesses at rising addresses, so a four-byte streaming transfer moves the pointer on by four.

Top module: `pkt_window_port`

## Requirements
- R1: After reset the page-number register and both pointer bytes read back as 0x00.
- R2: When pointer bit 15 is 1, window accesses use the page on `rx_head` and ignore the page-number register. When bit 15 is 0, they use the page-number register.
- R3: The byte position within the page is pointer bits [10:0]. Bits 13:11 do not affect which byte is accessed.
- R4: When pointer bit 14 is 1, each window read or write raises pointer bits [10:0] by one, wrapping from 0x7FF to 0x000, and leaves bits [15:11] unchanged.
- R5: When pointer bit 14 is 0, a window access leaves the pointer unchanged. It reaches the byte at position (bits [10:0] + `req_addr[1:0]`) modulo 2048.
- R6: A read of the pointer high byte (address 3) returns pointer bits [15:8] ANDed with 0xF7.
- R7: A write to address 2 replaces only pointer bits [7:0]. A write to address 3 replaces only bits [15:8].
- R8: A read issued in one cycle returns its byte on `rd_data` with `rd_valid` high in the next cycle. `rd_valid` is low in the cycle after any non-read cycle.
- R9: A write to address 0 stores the low log2(pages) bits of the data as the page number. A read of address 0 returns that number with zeros above it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Byte access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 3 | 0 page number, 1 unused (reads 0), 2 pointer low, 3 pointer high, 4..7 data window |
| req_wdata | input | 8 | Write byte |
| rx_head | input | 2 | Page at the receive queue head |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read byte |

## Verification
If the pointer register goes wrong, the next read of address 2 or 3 shows it, one cycle later. It also sends the following window access to the wrong byte, and the returned data differs from the pattern the bench expects at once. A wrong page choice, or a wrong lane offset, also shows on the first read that follows. The stored pattern depends on both page and position, so no two bytes are likely to alias. Errors in the increment or its wrap only appear at the page boundary, so the sweeps cross 0x7FF to 0x000 in both addressing styles.

// File: rtl/pwp_pkg.sv
package pwp_pkg;
  localparam int PTR_W      = 16;
  localparam int POS_W      = 11;
  localparam int SEL_BIT    = 15;
  localparam int AUTO_BIT   = 14;
  localparam logic [7:0] HI_MASK = 8'hF7;

  localparam logic [1:0] ADR_PNUM   = 2'd0;
  localparam logic [1:0] ADR_PTR_LO = 2'd2;
  localparam logic [1:0] ADR_PTR_HI = 2'd3;
endpackage

// File: rtl/pwp_regs.sv
module pwp_regs import pwp_pkg::*; #(
  parameter int PG_W  = 2,
  parameter int OFS_W = 11,
  localparam int BA_W = PG_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [2:0]         req_addr,
  input  logic [7:0]         req_wdata,
  input  logic [PG_W-1:0]    rx_head,
  output logic [PTR_W-1:0]   ptr_q,
  output logic [PG_W-1:0]    pnum_q,
  output logic [BA_W-1:0]    byte_addr
);
  logic [PTR_W-1:0] ptr_d;
  logic [PG_W-1:0]  pnum_d;
  logic             upd_en;
  logic [PG_W-1:0]  page;
  logic [POS_W-1:0] pos;

  assign upd_en = req_valid;

  always_comb begin
    ptr_d  = ptr_q;
    pnum_d = pnum_q;
    if (req_addr[2]) begin
      if (ptr_q[AUTO_BIT])
        ptr_d[POS_W-1:0] = ptr_q[POS_W-1:0] + POS_W'(1);
    end else if (req_write) begin
      case (req_addr[1:0])
        ADR_PNUM:   pnum_d      = req_wdata[PG_W-1:0];
        ADR_PTR_LO: ptr_d[7:0]  = req_wdata;
        ADR_PTR_HI: ptr_d[15:8] = req_wdata;
        default:    ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pnum_q <= '0;
    end else if (upd_en) begin
      ptr_q  <= ptr_d;
      pnum_q <= pnum_d;
    end
  end

  always_comb begin
    page = ptr_q[SEL_BIT] ? rx_head : pnum_q;
    if (ptr_q[AUTO_BIT])
      pos = ptr_q[POS_W-1:0];
    else
      pos = ptr_q[POS_W-1:0] + {{(POS_W-2){1'b0}}, req_addr[1:0]};
    byte_addr = {page, pos[OFS_W-1:0]};
  end
endmodule

// File: rtl/pwp_store.sv
module pwp_store #(
  parameter int WORDS = 2048,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] word_idx,
  input  logic [1:0]    lane,
  input  logic [7:0]    wdata,
  output logic [31:0]   word_q
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en)
      mem[word_idx][{lane, 3'b000} +: 8] <= wdata;
    if (rd_en)
      word_q <= mem[word_idx];
  end
endmodule

// File: rtl/pwp_rdret.sv
module pwp_rdret import pwp_pkg::*; #(
  parameter int PG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [2:0]       req_addr,
  input  logic [1:0]       mem_lane,
  input  logic [PTR_W-1:0] ptr_q,
  input  logic [PG_W-1:0]  pnum_q,
  input  logic [31:0]      mem_word,
  output logic             rd_valid,
  output logic [7:0]       rd_data
);
  logic [7:0] regval_d, regval_q;
  logic       from_mem_q;
  logic [1:0] lane_q;

  always_comb begin
    regval_d = '0;
    case (req_addr[1:0])
      ADR_PNUM:   regval_d[PG_W-1:0] = pnum_q;
      ADR_PTR_LO: regval_d = ptr_q[7:0];
      ADR_PTR_HI: regval_d = ptr_q[15:8] & HI_MASK;
      default:    regval_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid   <= 1'b0;
      regval_q   <= '0;
      from_mem_q <= 1'b0;
      lane_q     <= '0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        regval_q   <= regval_d;
        from_mem_q <= req_addr[2];
        lane_q     <= mem_lane;
      end
    end
  end

  assign rd_data = from_mem_q ? mem_word[{lane_q, 3'b000} +: 8] : regval_q;
endmodule

// File: rtl/pkt_window_port.sv
module pkt_window_port import pwp_pkg::*; #(
  parameter int PAGES      = 4,
  parameter int PAGE_BYTES = 2048,
  localparam int PG_W  = $clog2(PAGES),
  localparam int OFS_W = $clog2(PAGE_BYTES),
  localparam int BA_W  = PG_W + OFS_W,
  localparam int WORDS = PAGES * PAGE_BYTES / 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [2:0]      req_addr,
  input  logic [7:0]      req_wdata,
  input  logic [PG_W-1:0] rx_head,
  output logic            rd_valid,
  output logic [7:0]      rd_data
);
  logic [PTR_W-1:0] ptr_q;
  logic [PG_W-1:0]  pnum_q;
  logic [BA_W-1:0]  byte_addr;
  logic [31:0]      mem_word;
  logic             win_acc;

  assign win_acc = req_valid && req_addr[2];

  pwp_regs #(.PG_W(PG_W), .OFS_W(OFS_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rx_head(rx_head),
    .ptr_q(ptr_q), .pnum_q(pnum_q), .byte_addr(byte_addr)
  );

  pwp_store #(.WORDS(WORDS)) i_store (
    .clk(clk), .wr_en(win_acc && req_write), .rd_en(win_acc && !req_write),
    .word_idx(byte_addr[BA_W-1:2]), .lane(byte_addr[1:0]),
    .wdata(req_wdata), .word_q(mem_word)
  );

  pwp_rdret #(.PG_W(PG_W)) i_rdret (
    .clk(clk), .rst_n(rst_n), .rd_fire(req_valid && !req_write),
    .req_addr(req_addr), .mem_lane(byte_addr[1:0]), .ptr_q(ptr_q),
    .pnum_q(pnum_q), .mem_word(mem_word), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: rtl/pwp_checker.sv
module pwp_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [2:0]  req_addr,
  input logic [7:0]  req_wdata,
  input logic        rd_valid,
  input logic [7:0]  rd_data,
  input logic [15:0] ptr_q
);
  a_r8_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rd_valid);
  a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_write) |=> !rd_valid);
  a_r4_auto_step: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[2] && ptr_q[14]) |=>
      (ptr_q[10:0] == 11'($past(ptr_q[10:0]) + 11'd1)) &&
      (ptr_q[15:11] == $past(ptr_q[15:11])));
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_addr[2] && !ptr_q[14]) |=> $stable(ptr_q));
  a_r6_hi_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == 3'd3) |=> (rd_data[3] == 1'b0));
  a_r7_low_only: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 3'd2) |=>
      (ptr_q[15:8] == $past(ptr_q[15:8])) && (ptr_q[7:0] == $past(req_wdata)));
endmodule

bind pkt_window_port pwp_checker i_pwp_checker (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .rd_valid(rd_valid),
  .rd_data(rd_data), .ptr_q(ptr_q)
);

// File: tb/test_pkt_window_port.sv
module test_pkt_window_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       req_valid, req_write;
  logic [2:0] req_addr;
  logic [7:0] req_wdata;
  logic [1:0] rx_head;
  logic       rd_valid;
  logic [7:0] rd_data;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  pkt_window_port i_pkt_window_port (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rx_head(rx_head),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int p, input int i);
    return 8'((p * 37 + i * 5 + (i >> 8)) & 255);
  endfunction

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] q, output logic v);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = 8'h00;
    @(negedge clk);
    q = rd_data; v = rd_valid;
    req_valid = 1'b0;
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr(3'd2, p[7:0]);
    wr(3'd3, p[15:8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic v;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0;
    req_wdata = '0; rx_head = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(3'd0, q, v); chk("R1 pnum", q, 8'h00);
    chk("R8 rd_valid after read", {7'd0, v}, 8'h01);
    rd(3'd2, q, v); chk("R1 ptr lo", q, 8'h00);
    rd(3'd3, q, v); chk("R1 ptr hi", q, 8'h00);

    // R9 page number truncation
    wr(3'd0, 8'hFE);
    chk("R8 rd_valid after write", {7'd0, rd_valid}, 8'h00);
    rd(3'd0, q, v); chk("R9 pnum", q, 8'h02);

    // R7 / R6 sweep of the low byte with a fixed high byte
    wr(3'd3, 8'h5A);
    for (int i = 0; i < 256; i++) begin
      wr(3'd2, 8'(i));
      rd(3'd2, q, v); chk("R7 lo", q, 8'(i));
      rd(3'd3, q, v); chk("R7 hi kept / R6", q, 8'h52);
    end
    for (int i = 0; i < 256; i++) begin
      wr(3'd3, 8'(i));
      rd(3'd3, q, v); chk("R6 hi mask", q, 8'(i) & 8'hF7);
      rd(3'd2, q, v); chk("R7 lo kept", q, 8'hFF);
    end

    // Fill all pages by page number with auto increment (R2, R4)
    for (int p = 0; p < 4; p++) begin
      wr(3'd0, 8'(p));
      set_ptr(16'h4000);
      for (int i = 0; i < 2048; i++) wr(3'(4 + (i % 4)), pat(p, i));
      rd(3'd2, q, v); chk("R4 wrap lo", q, 8'h00);
      rd(3'd3, q, v); chk("R4 wrap hi", q, 8'h40);
    end

    // Read back through the receive head with a different page number (R2, R3, R4)
    for (int p = 0; p < 4; p++) begin
      rx_head = 2'(p);
      wr(3'd0, 8'((p + 1) % 4));
      set_ptr(16'hC000);
      for (int i = 0; i < 2048; i++) begin
        rd(3'(4 + ((i + p) % 4)), q, v);
        chk("R2 R4 rx-head stream", q, pat(p, i));
      end
    end

    // R2 page number path without bit 15
    rx_head = 2'd0;
    wr(3'd0, 8'd3);
    set_ptr(16'h0123);
    rd(3'd4, q, v); chk("R2 pnum page", q, pat(3, 16'h123));

    // R5 lane offset with wrap, pointer held
    wr(3'd0, 8'd2);
    set_ptr(16'h07FE);
    rd(3'd4, q, v); chk("R5 lane0", q, pat(2, 2046));
    rd(3'd5, q, v); chk("R5 lane1", q, pat(2, 2047));
    rd(3'd6, q, v); chk("R5 lane2 wrap", q, pat(2, 0));
    rd(3'd7, q, v); chk("R5 lane3 wrap", q, pat(2, 1));
    rd(3'd2, q, v); chk("R5 ptr lo held", q, 8'hFE);
    rd(3'd3, q, v); chk("R5 ptr hi held", q, 8'h07);

    // R5 lane write lands at offset + lane
    wr(3'd0, 8'd1);
    set_ptr(16'h0010);
    wr(3'd5, 8'h99);
    rd(3'd2, q, v); chk("R5 ptr held after write", q, 8'h10);
    set_ptr(16'h4010);
    rd(3'd4, q, v); chk("R5 neighbour untouched", q, pat(1, 16));
    rd(3'd4, q, v); chk("R5 lane write", q, 8'h99);

    // R3 bit 11 does not move the byte; R6 masks it on read
    wr(3'd0, 8'd3);
    set_ptr(16'h0805);
    rd(3'd4, q, v); chk("R3 bit11 ignored", q, pat(3, 5));
    rd(3'd3, q, v); chk("R6 bit11 masked", q, 8'h00);

    // R4 wrap keeps bits 15:11
    wr(3'd0, 8'd0);
    set_ptr(16'h4FFF);
    rd(3'd4, q, v); chk("R4 last byte", q, pat(0, 2047));
    rd(3'd2, q, v); chk("R4 wrap lo keep", q, 8'h00);
    rd(3'd3, q, v); chk("R4 wrap hi keep", q, 8'h40);
    rd(3'd4, q, v); chk("R4 first byte", q, pat(0, 0));

    // R4 four-byte transfer advances by four
    set_ptr(16'h4100);
    for (int i = 0; i < 4; i++) begin
      rd(3'(4 + i), q, v); chk("R4 burst", q, pat(0, 256 + i));
    end
    rd(3'd2, q, v); chk("R4 burst ptr", q, 8'h04);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule